// File: doc/BRIEF.md
# Embedded RAM Self-Test Controller (four lanes)

This block runs built-in self-test on four single-port embedded RAMs. Each RAM has its own lane. A lane takes a 2-bit mode from a shared 32-bit configuration word. In its functional mode the lane passes the functional address, write data and write enable straight through to the RAM. In its test modes the lane's engine takes sole control of the RAM port and runs a sequence of writes and reads. Each lane reports a `done` flag and a `fail` flag, which feed a result register.

There are two test modes:
- **March test.** A March C- test runs over the whole address range. Every read is compared against the solid background the test expects.
- **Detector check.** A short sequence writes a zero word and then reads it back against an inverted expectation. A working comparator must flag it, which proves the error detector can report a failure.

Software holds a test code until `done` reads 1. Returning the code to functional mode clears both flags. Changing the code before `done` abandons the run.

Top module: `mbist_quad`

## Requirements
- R1: Lane i takes its mode from `cfg_word[21-2i:20-2i]`, so lane 0 uses bits 21:20 and lane 3 uses bits 15:14. Bits 31:22 and 13:0 have no effect on any lane.
- R2: After reset every lane shows `done`=0 and `fail`=0, and the lane's RAM port outputs equal its functional inputs.
- R3: Mode code 00 and mode code 11 both give functional pass-through. No test starts and both flags stay 0.
- R4: Mode code 01 runs March C- on a 2^AW-word RAM with a one-cycle read latency. The test ends 11*2^AW clock edges after the edge that samples the code, with `done`=1. On a fault-free RAM, `fail`=0.
- R5: A read that differs from the expected all-zeros or all-ones word sets `fail`. Once set, `fail` stays 1 for as long as the test code is held.
- R6: Mode code 10 runs the detector check. On a fault-free RAM it ends with `done`=1 and `fail`=1.
- R7: If the code leaves 01 or 10 before `done` is set, the run is abandoned. One edge later `done`=0, `fail`=0, and the port is back in pass-through.
- R8: While a test code is active, functional write data never reaches the RAM. The test drives only all-zeros or all-ones data.
- R9: `done` holds while the test code is held. One edge after the code becomes 00, both flags read 0.
- R10: Lanes are independent. A lane in test does not affect the pass-through or the flags of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 32 | Shared configuration word holding the four mode fields |
| func_addr | input | NUM_RAMS*AW | Functional addresses, lane i at [i*AW +: AW] |
| func_wdata | input | NUM_RAMS*DW | Functional write data, lane i at [i*DW +: DW] |
| func_we | input | NUM_RAMS | Functional write enables |
| ram_rdata | input | NUM_RAMS*DW | Read data from each RAM, valid one cycle after a read |
| ram_addr | output | NUM_RAMS*AW | Address to each RAM |
| ram_wdata | output | NUM_RAMS*DW | Write data to each RAM |
| ram_we | output | NUM_RAMS | Write enable to each RAM |
| done_flags | output | NUM_RAMS | Per-lane test-complete flag |
| fail_flags | output | NUM_RAMS | Per-lane test-failed flag |

## Verification
The bench injects a stuck-at-1 bit into one lane's RAM read data. A comparator that is dead or that compares against the wrong background would then report a clean March pass. The detector-check code must fail on a perfect RAM; an engine that skipped the inverted expectation would report 0 there.

The bench aborts a run that has already failed by returning the code to 00. A design that kept `fail` sticky across runs, or that left the port under test control, is caught one edge later.

The bench checks `done` on the exact edge the March sequence should finish, which exposes an off-by-one in the address walk or a missing march element. Unused configuration bits set to ones and the reserved code 11 test the mode decode and the field positions.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
   typedef enum logic [1:0] {
      MODE_FUNC  = 2'b00,
      MODE_MARCH = 2'b01,
      MODE_CHK   = 2'b10,
      MODE_RSVD  = 2'b11
   } mbist_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR,
      ST_RD,
      ST_CMP,
      ST_DONE
   } mbist_state_e;

   // march elements: 0 up w0, 1 up r0w1, 2 up r1w0, 3 down r0w1, 4 down r1w0, 5 up r0
   localparam logic [2:0] EL_FIRST_RW = 3'd1;
   localparam logic [2:0] EL_LAST     = 3'd5;
   localparam logic [2:0] EL_CTRL     = 3'd6;
endpackage

// File: rtl/mbist_engine.sv
module mbist_engine
   import mbist_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] bist_addr,
   output logic [DW-1:0] bist_wdata,
   output logic          bist_we,
   output logic          bist_own,
   output logic          done,
   output logic          fail
);
   localparam logic [AW-1:0] ADDR_MAX = '1;

   mbist_state_e st_q;
   logic [2:0]    elem_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    runmode_q;
   logic          fail_q;

   logic          test_req, elem_down, last_addr, exp_ones, wr_after, wr_ones, mismatch;
   logic [2:0]    elem_nxt;
   logic [AW-1:0] start_nxt;

   always_comb begin
      test_req  = (mode == MODE_MARCH) || (mode == MODE_CHK);
      elem_down = (elem_q == 3'd3) || (elem_q == 3'd4);
      last_addr = (elem_q == EL_CTRL) || (elem_down ? (addr_q == '0) : (addr_q == ADDR_MAX));
      exp_ones  = (elem_q == 3'd2) || (elem_q == 3'd4) || (elem_q == EL_CTRL);
      wr_after  = (elem_q >= EL_FIRST_RW) && (elem_q <= 3'd4);
      wr_ones   = (elem_q == 3'd1) || (elem_q == 3'd3);
      mismatch  = ram_rdata != (exp_ones ? {DW{1'b1}} : {DW{1'b0}});
      elem_nxt  = elem_q + 3'd1;
      start_nxt = ((elem_nxt == 3'd3) || (elem_nxt == 3'd4)) ? ADDR_MAX : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         elem_q    <= '0;
         addr_q    <= '0;
         runmode_q <= MODE_FUNC;
         fail_q    <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         fail_q <= 1'b0;
         if (test_req) begin
            runmode_q <= mode;
            addr_q    <= '0;
            elem_q    <= (mode == MODE_CHK) ? EL_CTRL : 3'd0;
            st_q      <= ST_WR;
         end
      end else if (mode != runmode_q) begin
         st_q   <= ST_IDLE;
         fail_q <= 1'b0;
      end else begin
         case (st_q)
            ST_WR: begin
               if (elem_q == EL_CTRL) begin
                  st_q <= ST_RD;
               end else if (addr_q == ADDR_MAX) begin
                  elem_q <= EL_FIRST_RW;
                  addr_q <= '0;
                  st_q   <= ST_RD;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            ST_RD: st_q <= ST_CMP;
            ST_CMP: begin
               if (mismatch) fail_q <= 1'b1;
               if (last_addr) begin
                  if ((elem_q == EL_LAST) || (elem_q == EL_CTRL)) begin
                     st_q <= ST_DONE;
                  end else begin
                     elem_q <= elem_nxt;
                     addr_q <= start_nxt;
                     st_q   <= ST_RD;
                  end
               end else begin
                  addr_q <= elem_down ? addr_q - 1'b1 : addr_q + 1'b1;
                  st_q   <= ST_RD;
               end
            end
            default: ;
         endcase
      end
   end

   assign bist_addr  = addr_q;
   assign bist_we    = (st_q == ST_WR) || ((st_q == ST_CMP) && wr_after);
   assign bist_wdata = ((st_q == ST_CMP) && wr_ones) ? {DW{1'b1}} : {DW{1'b0}};
   assign bist_own   = (st_q != ST_IDLE);
   assign done       = (st_q == ST_DONE);
   assign fail       = fail_q;
endmodule

// File: rtl/mbist_port_mux.sv
module mbist_port_mux #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          own,
   input  logic [AW-1:0] bist_addr,
   input  logic [DW-1:0] bist_wdata,
   input  logic          bist_we,
   input  logic [AW-1:0] func_addr,
   input  logic [DW-1:0] func_wdata,
   input  logic          func_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   output logic          ram_we
);
   always_comb begin
      if (own) begin
         ram_addr  = bist_addr;
         ram_wdata = bist_wdata;
         ram_we    = bist_we;
      end else begin
         ram_addr  = func_addr;
         ram_wdata = func_wdata;
         ram_we    = func_we;
      end
   end
endmodule

// File: rtl/mbist_quad.sv
module mbist_quad #(
   parameter int NUM_RAMS = 4,
   parameter int AW       = 4,
   parameter int DW       = 8,
   parameter int MODE_HI  = 21
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [31:0]            cfg_word,
   input  logic [NUM_RAMS*AW-1:0] func_addr,
   input  logic [NUM_RAMS*DW-1:0] func_wdata,
   input  logic [NUM_RAMS-1:0]    func_we,
   input  logic [NUM_RAMS*DW-1:0] ram_rdata,
   output logic [NUM_RAMS*AW-1:0] ram_addr,
   output logic [NUM_RAMS*DW-1:0] ram_wdata,
   output logic [NUM_RAMS-1:0]    ram_we,
   output logic [NUM_RAMS-1:0]    done_flags,
   output logic [NUM_RAMS-1:0]    fail_flags
);
   localparam int FIELD_W = 2;
   localparam int MODE_LO = MODE_HI - FIELD_W * NUM_RAMS + 1;

   if (MODE_HI > 31 || MODE_LO < 0) begin : g_bad_field
      $error("mode fields do not fit the configuration word");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("address and data widths must be positive");
   end

   logic unused_cfg;
   assign unused_cfg = ^cfg_word;

   for (genvar i = 0; i < NUM_RAMS; i++) begin : g_lane
      logic [1:0]    lane_mode;
      logic [AW-1:0] b_addr;
      logic [DW-1:0] b_wdata;
      logic          b_we, b_own;

      assign lane_mode = cfg_word[MODE_HI - FIELD_W*i -: FIELD_W];

      mbist_engine #(.AW(AW), .DW(DW)) eng_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (lane_mode),
         .ram_rdata (ram_rdata[i*DW +: DW]),
         .bist_addr (b_addr),
         .bist_wdata(b_wdata),
         .bist_we   (b_we),
         .bist_own  (b_own),
         .done      (done_flags[i]),
         .fail      (fail_flags[i])
      );

      mbist_port_mux #(.AW(AW), .DW(DW)) mux_i (
         .own       (b_own),
         .bist_addr (b_addr),
         .bist_wdata(b_wdata),
         .bist_we   (b_we),
         .func_addr (func_addr[i*AW +: AW]),
         .func_wdata(func_wdata[i*DW +: DW]),
         .func_we   (func_we[i]),
         .ram_addr  (ram_addr[i*AW +: AW]),
         .ram_wdata (ram_wdata[i*DW +: DW]),
         .ram_we    (ram_we[i])
      );
   end
endmodule

// File: rtl/mbist_quad_chk.sv
module mbist_quad_chk #(
   parameter int NUM_RAMS = 4,
   parameter int MODE_HI  = 21
) (
   input logic                clk,
   input logic                rst_n,
   input logic [31:0]         cfg_word,
   input logic [NUM_RAMS-1:0] func_we,
   input logic [NUM_RAMS-1:0] ram_we,
   input logic [NUM_RAMS-1:0] done_flags,
   input logic [NUM_RAMS-1:0] fail_flags
);
   logic unused_chk;
   assign unused_chk = ^cfg_word;

   for (genvar i = 0; i < NUM_RAMS; i++) begin : g_chk
      logic [1:0] md;
      logic       md_test;
      assign md      = cfg_word[MODE_HI - 2*i -: 2];
      assign md_test = (md == 2'b01) || (md == 2'b10);

      AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (!md_test && !$past(md_test)) |-> (ram_we[i] == func_we[i])); // R3
      AST_DONE_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done_flags[i]) |-> ($past(md) == 2'b01 || $past(md) == 2'b10)); // R9
      AST_CLEAR_ON_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
         (md == 2'b00) |=> (!done_flags[i] && !fail_flags[i])); // R9
      AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (fail_flags[i] && md_test && $stable(md)) |=> fail_flags[i]); // R5
      AST_CHK_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
         (done_flags[i] && md == 2'b10 && $stable(md)) |-> fail_flags[i]); // R6
   end
endmodule

bind mbist_quad mbist_quad_chk #(.NUM_RAMS(NUM_RAMS), .MODE_HI(MODE_HI)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_word  (cfg_word),
   .func_we   (func_we),
   .ram_we    (ram_we),
   .done_flags(done_flags),
   .fail_flags(fail_flags)
);

// File: tb/mbist_quad_tb_top.sv
module mbist_quad_tb_top;
   localparam int N     = 4;
   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;
   localparam int WAIT  = 11 * DEPTH + 4;

   // {cfg, fault mask, expected done, expected fail}
   localparam logic [43:0] VECS [6] = '{
      {32'h0010_0000, 4'h0, 4'h1, 4'h0},
      {32'h0015_4000, 4'h0, 4'hF, 4'h0},
      {32'h002A_8000, 4'h0, 4'hF, 4'hF},
      {32'h0015_4000, 4'h4, 4'hF, 4'h4},
      {32'hFFED_3FFF, 4'h2, 4'h5, 4'h1},
      {32'h003F_C000, 4'hF, 4'h0, 4'h0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0]     cfg_word = '0;
   logic [N*AW-1:0] func_addr = '0;
   logic [N*DW-1:0] func_wdata = '0;
   logic [N-1:0]    func_we = '0;
   logic [N*DW-1:0] ram_rdata;
   logic [N*AW-1:0] ram_addr;
   logic [N*DW-1:0] ram_wdata;
   logic [N-1:0]    ram_we, done_flags, fail_flags;
   logic [N-1:0]    fault = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mbist_quad #(.NUM_RAMS(N), .AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .func_addr(func_addr), .func_wdata(func_wdata), .func_we(func_we),
      .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_we(ram_we), .done_flags(done_flags), .fail_flags(fail_flags)
   );

   for (genvar g = 0; g < N; g++) begin : g_ram
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] rd_q = '0;
      always_ff @(posedge clk) begin
         if (ram_we[g]) mem[ram_addr[g*AW +: AW]] <= ram_wdata[g*DW +: DW];
         else rd_q <= mem[ram_addr[g*AW +: AW]] | {{(DW-1){1'b0}}, fault[g]};
      end
      assign ram_rdata[g*DW +: DW] = rd_q;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic go_func();
      @(negedge clk);
      cfg_word = '0;
      fault = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      func_addr = 16'h7A52; func_wdata = 32'h1122_3344; func_we = 4'b1010;
      @(posedge clk); #1;
      chk(done_flags == 0 && fail_flags == 0, "R2 flags after reset", {done_flags, fail_flags}, 0);
      chk(ram_addr == func_addr && ram_wdata == func_wdata && ram_we == func_we,
          "R2 pass-through after reset", {ram_addr, ram_we}, {func_addr, func_we});

      // vector table walk: R1 R3 R4 R5 R6 R10
      for (int v = 0; v < 6; v++) begin
         go_func();
         fault = VECS[v][11:8];
         cfg_word = VECS[v][43:12];
         repeat (WAIT) @(posedge clk); #1;
         chk(done_flags == VECS[v][7:4], $sformatf("R1/R4 done vec%0d", v), done_flags, VECS[v][7:4]);
         chk(fail_flags == VECS[v][3:0], $sformatf("R5/R6 fail vec%0d", v), fail_flags, VECS[v][3:0]);
      end

      // R4 exact completion edge
      go_func();
      cfg_word = 32'h0010_0000;
      repeat (11 * DEPTH) @(posedge clk); #1;
      chk(done_flags[0] == 1'b0, "R4 done one edge early", done_flags[0], 0);
      @(posedge clk); #1;
      chk(done_flags[0] == 1'b1 && fail_flags[0] == 1'b0, "R4 done on time", {done_flags[0], fail_flags[0]}, 2'b10);
      repeat (5) @(posedge clk); #1;
      chk(done_flags[0] == 1'b1, "R9 done held", done_flags[0], 1);
      @(negedge clk);
      cfg_word = '0;
      @(posedge clk); #1;
      chk(done_flags == 0 && fail_flags == 0, "R9 flags cleared", {done_flags, fail_flags}, 0);

      // R7 abort after a failure has been seen
      go_func();
      fault = 4'h1;
      cfg_word = 32'h0010_0000;
      repeat (30) @(posedge clk); #1;
      chk(fail_flags[0] == 1'b1 && done_flags[0] == 1'b0, "R5 fail during run", {fail_flags[0], done_flags[0]}, 2'b10);
      @(negedge clk);
      cfg_word = '0;
      func_we = 4'b0001; func_addr = 16'h000C; func_wdata = 32'h0000_005A;
      @(posedge clk); #1;
      chk(done_flags[0] == 0 && fail_flags[0] == 0, "R7 abort clears flags", {done_flags[0], fail_flags[0]}, 0);
      chk(ram_we[0] == 1'b1 && ram_addr[3:0] == 4'hC && ram_wdata[7:0] == 8'h5A,
          "R7 port returned", {ram_we[0], ram_addr[3:0], ram_wdata[7:0]}, {1'b1, 4'hC, 8'h5A});

      // R8 functional data blocked, R10 other lane untouched
      go_func();
      func_we = 4'b1111; func_wdata = 32'hA5A5_3CA5; func_addr = 16'h0090;
      cfg_word = 32'h0015_0000;
      begin
         int leaks = 0;
         for (int c = 0; c < 40; c++) begin
            @(posedge clk); #1;
            for (int l = 0; l < 3; l++)
               if (ram_wdata[l*DW +: DW] == 8'hA5 || ram_wdata[l*DW +: DW] == 8'h3C) leaks++;
         end
         chk(leaks == 0, "R8 functional data blocked", leaks, 0);
      end
      chk(ram_addr[15:12] == 4'h0 && ram_wdata[31:24] == 8'hA5 && ram_we[3] == 1'b1,
          "R10 idle lane passes through", {ram_addr[15:12], ram_wdata[31:24]}, {4'h0, 8'hA5});
      chk(done_flags[3] == 0 && fail_flags[3] == 0, "R10 idle lane flags", {done_flags[3], fail_flags[3]}, 0);

      // R3 reserved code on lane 2 alone
      go_func();
      func_we = 4'b0100; func_addr = 16'h0B00; func_wdata = 32'h00C3_0000;
      cfg_word = 32'h0003_0000;
      repeat (WAIT) @(posedge clk); #1;
      chk(done_flags == 0 && ram_we[2] && ram_addr[11:8] == 4'hB && ram_wdata[23:16] == 8'hC3,
          "R3 code 11 stays functional", {done_flags, ram_addr[11:8]}, {4'h0, 4'hB});

      finish_run();
   end
endmodule